// File: doc/BRIEF.md
# Accumulating Multiply Unit with Private 64-bit Accumulator

This execution unit sits beside a processor pipeline. It keeps one private accumulator that is twice the register width. It watches a stream of instruction words with their two source operand values. When a word carries the unit's custom major opcode, the unit decodes it. It can clear the accumulator, hand back one half of it to a destination register, or fold the product of the two operands into it.

Multiply-accumulate comes in two widths. The narrow form keeps only the low word of the product and adds it to the low word of the accumulator. It then writes that word back and zeroes the high word. The wide form adds the full double-width product to the whole accumulator and wraps. Each width has an unsigned variant and a signed (two's complement) variant. Any other function code under the custom opcode is flagged as illegal. Words with any other opcode are ignored.

All results are registered. An instruction sampled at one rising edge shows its write-back request, or its illegal flag, for exactly the following cycle. An accumulator update lands on that same edge, so an instruction on the very next cycle already sees the new value.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset (rst_ni low), the accumulator is zero and rd_we_o and illegal_o are low.
- R2: An instruction is accepted when valid_i is high and instr_i[6:0] = 7'b0001011. Its fields are funct3 = instr_i[14:12], funct7 = instr_i[31:25] and rd = instr_i[11:7]. funct3 = 0 with funct7 = 0 sets the accumulator to zero.
- R3: funct3 = 0 with funct7 = 1 returns accumulator bits [31:0]. On the next cycle result_o holds them, rd_we_o is high and rd_addr_o equals rd.
- R4: funct3 = 0 with funct7 = 2 returns accumulator bits [63:32] in the same way as R3.
- R5: A read (R3 or R4) whose rd is 0 leaves rd_we_o low.
- R6: funct3 = 1 with funct7 = 0 or 1 replaces the accumulator with {32'b0, acc[31:0] + (rs1*rs2)[31:0]} (mod 2^32). Signed and unsigned give the same low word.
- R7: funct3 = 2 with funct7 = 0 adds the unsigned 64-bit product rs1*rs2 to the accumulator, modulo 2^64.
- R8: funct3 = 2 with funct7 = 1 adds the signed 64-bit product of rs1 and rs2, both taken as two's complement, to the accumulator, modulo 2^64.
- R9: Clear and multiply-accumulate instructions never raise rd_we_o.
- R10: Under the custom opcode, any funct3/funct7 pair not listed in R2 to R8 raises illegal_o on the next cycle and leaves the accumulator unchanged.
- R11: A word with any other opcode, or with valid_i low, changes no state. On the next cycle rd_we_o and illegal_o are low.
- R12: An instruction that directly follows an accumulator update observes the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | 32 | First source operand value |
| rs2_i | input | 32 | Second source operand value |
| result_o | output | 32 | Read-back data, meaningful when rd_we_o is high |
| rd_we_o | output | 1 | Destination register write request, one cycle |
| rd_addr_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Illegal instruction under the custom opcode, one cycle |

## Verification
The bench builds the unit with its default register width of 32, so the accumulator is 64 bits wide. At that size a 64-bit reference model in the bench matches it exactly. It is then practical to drive full-range operands, including all-ones products and accumulator values near 2^64 that force wrap-around. Random mixes of every legal operation, illegal function codes and foreign opcodes are interleaved with read-backs of both halves. This catches an upper half that is not cleared by the narrow form, and sign errors in the wide signed form.

// File: rtl/mac_acc_pkg.sv
package mac_acc_pkg;
  localparam int unsigned IW = 32;
  localparam logic [6:0] OPC_MAC = 7'b0001011;

  localparam logic [2:0] F3_CTRL  = 3'd0;
  localparam logic [2:0] F3_MAC32 = 3'd1;
  localparam logic [2:0] F3_MAC64 = 3'd2;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLR,
    OP_RD_LO,
    OP_RD_HI,
    OP_MAC32,
    OP_MACU64,
    OP_MACS64,
    OP_ILL
  } mac_op_e;

  typedef struct packed {
    mac_op_e    op;
    logic [4:0] rd;
  } dec_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_acc_pkg::*;
(
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  logic [6:0] opc, f7;
  logic [2:0] f3;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign f7  = instr_i[31:25];

  always_comb begin
    dec_o.rd = instr_i[11:7];
    dec_o.op = OP_NONE;
    if (valid_i && opc == OPC_MAC) begin
      dec_o.op = OP_ILL;
      unique case (f3)
        F3_CTRL: begin
          if      (f7 == 7'd0) dec_o.op = OP_CLR;
          else if (f7 == 7'd1) dec_o.op = OP_RD_LO;
          else if (f7 == 7'd2) dec_o.op = OP_RD_HI;
        end
        F3_MAC32: if (f7 == 7'd0 || f7 == 7'd1) dec_o.op = OP_MAC32;
        F3_MAC64: begin
          if      (f7 == 7'd0) dec_o.op = OP_MACU64;
          else if (f7 == 7'd1) dec_o.op = OP_MACS64;
        end
        default: dec_o.op = OP_ILL;
      endcase
    end
  end
endmodule

// File: rtl/mac_step.sv
module mac_step
  import mac_acc_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned AW  = 2 * XLEN
) (
  input  mac_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [AW-1:0]   acc_i,
  output logic [AW-1:0]   acc_o,
  output logic            upd_o
);
  logic [AW-1:0]   a_ext, b_ext, prod;
  logic [XLEN-1:0] lo_sum;
  logic            sgn;

  assign sgn   = (op_i == OP_MACS64);
  // sign extension before a plain multiply gives the two's complement product mod 2^AW
  assign a_ext = {{XLEN{sgn & a_i[XLEN-1]}}, a_i};
  assign b_ext = {{XLEN{sgn & b_i[XLEN-1]}}, b_i};
  assign prod  = a_ext * b_ext;
  assign lo_sum = acc_i[XLEN-1:0] + prod[XLEN-1:0];

  always_comb begin
    upd_o = 1'b1;
    acc_o = acc_i;
    unique case (op_i)
      OP_CLR:               acc_o = '0;
      OP_MAC32:             acc_o = {{XLEN{1'b0}}, lo_sum};
      OP_MACU64, OP_MACS64: acc_o = acc_i + prod;
      default:              upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_acc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [IW-1:0]   instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] result_o,
  output logic            rd_we_o,
  output logic [4:0]      rd_addr_o,
  output logic            illegal_o
);
  localparam int unsigned AW = 2 * XLEN;

  dec_t          dec;
  logic [AW-1:0] acc_q, acc_d;
  logic          acc_upd;

  mac_decode i_dec (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  mac_step #(.XLEN(XLEN)) i_step (
    .op_i  (dec.op),
    .a_i   (rs1_i),
    .b_i   (rs2_i),
    .acc_i (acc_q),
    .acc_o (acc_d),
    .upd_o (acc_upd)
  );

  mac_acc_reg #(.AW(AW)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (acc_upd),
    .d_i    (acc_d),
    .q_o    (acc_q)
  );

  logic rd_nz;
  assign rd_nz = (dec.rd != 5'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      rd_we_o   <= 1'b0;
      rd_addr_o <= '0;
      illegal_o <= 1'b0;
    end else begin
      rd_we_o   <= (dec.op == OP_RD_LO || dec.op == OP_RD_HI) && rd_nz;
      illegal_o <= (dec.op == OP_ILL);
      rd_addr_o <= dec.rd;
      result_o  <= (dec.op == OP_RD_HI) ? acc_q[AW-1:XLEN] : acc_q[XLEN-1:0];
    end
  end

  a_r1_reset_clean: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (acc_q == '0 && !rd_we_o && !illegal_o));

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.op == OP_CLR) |=> (acc_q == '0));

  a_r6_upper_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.op == OP_MAC32) |=> (acc_q[AW-1:XLEN] == '0));

  a_r5_no_write_r0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_addr_o != 5'd0));

  a_r10_illegal_holds_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.op == OP_ILL) |=> (illegal_o && acc_q == $past(acc_q)));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!rd_we_o && !illegal_o && $stable(acc_q)));

  a_r9_outputs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_we_o && illegal_o));
endmodule

// File: tb/test_mac_acc_unit.sv
module test_mac_acc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] result;
  logic        rd_we, illegal;
  logic [4:0]  rd_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] m_acc = '0;

  always #2 clk = ~clk;

  mac_acc_unit i_mac_acc_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .rs1_i(a), .rs2_i(b), .result_o(result), .rd_we_o(rd_we),
    .rd_addr_o(rd_addr), .illegal_o(illegal)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {f7, 5'd3, 5'd4, f3, rd, opc};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] x, input logic [31:0] y);
    logic [6:0] opc = ins[6:0];
    logic [2:0] f3  = ins[14:12];
    logic [6:0] f7  = ins[31:25];
    logic [4:0] rd  = ins[11:7];
    bit e_we = 0, e_ill = 0;
    logic [31:0] e_res = '0;
    logic [63:0] p;
    string tag = "R11";
    valid = v; instr = ins; a = x; b = y;
    if (v && opc == 7'b0001011) begin
      e_ill = 1; tag = "R10";
      if (f3 == 3'd0) begin
        if (f7 == 7'd0) begin e_ill = 0; tag = "R2"; m_acc = '0; end
        else if (f7 == 7'd1) begin e_ill = 0; tag = (rd == 0) ? "R5" : "R3"; e_we = (rd != 0); e_res = m_acc[31:0]; end
        else if (f7 == 7'd2) begin e_ill = 0; tag = (rd == 0) ? "R5" : "R4"; e_we = (rd != 0); e_res = m_acc[63:32]; end
      end else if (f3 == 3'd1 && f7 <= 7'd1) begin
        e_ill = 0; tag = "R6";
        m_acc = {32'd0, m_acc[31:0] + (x * y)};
      end else if (f3 == 3'd2 && f7 <= 7'd1) begin
        e_ill = 0;
        if (f7 == 7'd1) begin
          tag = "R8";
          p = 64'($signed(64'($signed(x))) * $signed(64'($signed(y))));
        end else begin
          tag = "R7";
          p = {32'd0, x} * {32'd0, y};
        end
        m_acc = m_acc + p;
      end
    end
    @(negedge clk);
    chk(rd_we == e_we, {tag, "/R9 write enable"}, 64'(rd_we), 64'(e_we));
    chk(illegal == e_ill, {tag, " illegal flag"}, 64'(illegal), 64'(e_ill));
    if (e_we) begin
      chk(rd_addr == rd, {tag, " rd index"}, 64'(rd_addr), 64'(rd));
      chk(result == e_res, {tag, "/R12 read data"}, 64'(result), 64'(e_res));
    end
  endtask

  task automatic read_both();
    step(1, mk(7'd1, 3'd0, 5'd7, 7'b0001011), '0, '0);
    step(1, mk(7'd2, 3'd0, 5'd9, 7'b0001011), '0, '0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_we == 0 && illegal == 0, "R1 outputs after reset", {62'd0, rd_we, illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_both();

    // R7 wrap: all-ones products near 2^64
    step(1, mk(7'd0, 3'd2, 5'd0, 7'b0001011), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, mk(7'd0, 3'd2, 5'd0, 7'b0001011), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    read_both();
    step(1, mk(7'd0, 3'd2, 5'd0, 7'b0001011), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    read_both();
    // R6: upper half cleared
    step(1, mk(7'd1, 3'd1, 5'd0, 7'b0001011), 32'hFFFF_FFFF, 32'd3);
    read_both();
    // R8: signed -1 * -1 and -1 * 5
    step(1, mk(7'd1, 3'd2, 5'd0, 7'b0001011), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, mk(7'd1, 3'd2, 5'd0, 7'b0001011), 32'hFFFF_FFFF, 32'd5);
    read_both();
    // R5: read to r0
    step(1, mk(7'd1, 3'd0, 5'd0, 7'b0001011), '0, '0);
    step(1, mk(7'd2, 3'd0, 5'd0, 7'b0001011), '0, '0);
    // R10: illegal codes leave acc intact
    step(1, mk(7'd3, 3'd0, 5'd1, 7'b0001011), '0, '0);
    step(1, mk(7'd2, 3'd2, 5'd0, 7'b0001011), 32'd7, 32'd7);
    step(1, mk(7'd0, 3'd5, 5'd0, 7'b0001011), 32'd7, 32'd7);
    read_both();
    // R11: foreign opcode and idle
    step(1, mk(7'd0, 3'd2, 5'd0, 7'b0101011), 32'd9, 32'd9);
    step(0, mk(7'd0, 3'd2, 5'd0, 7'b0001011), 32'd9, 32'd9);
    read_both();
    // R2: clear
    step(1, mk(7'd0, 3'd0, 5'd0, 7'b0001011), '0, '0);
    read_both();

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      logic [6:0] f7;
      logic [2:0] f3;
      logic [6:0] opc = (r[3:0] == 4'd0) ? 7'b0110011 : 7'b0001011;
      f3 = (r[7:4] == 4'd0) ? 3'(r[10:8]) : 3'(r[9:8] % 3);
      f7 = (r[15:12] == 4'd0) ? 7'(r[22:16]) : 7'(r[17:16] % 3);
      step(r[31:28] != 4'd0, mk(f7, f3, 5'(r[27:23]), opc), $urandom, $urandom);
    end
    read_both();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule